// File: doc/BRIEF.md
# NAND Flash Command Sequencer

The sequencer turns one packed command word into the byte-level activity of a raw NAND flash bus. Software first loads a column register, a page register and, if needed, a ready-timeout limit. It then writes the command word. The block drives the opcode with the command latch, then drives the address bytes that the word's mask selects, each with the address latch. If the word asks for it, the block then waits for the flash ready line. Last, it moves the requested number of data bytes, either from a write byte-stream to the flash or from the flash to a read byte-stream.

Operations with more than one phase, such as page read, page program and block erase, are built by issuing two command words in turn. An example is opcode 0x00 with all five address bytes, followed by opcode 0x30 with wait-for-ready and a 0x840-byte read. Program and erase opcodes that aim outside an allowed page window are refused: the flash bus stays quiet and the error flag is set.

When an operation ends, the busy flag drops and an optional one-cycle interrupt is raised. The error flag is set if the operation was refused or the ready line timed out.

Top module: `nfc_seq`

## Requirements
- R1: After reset the status word reads 0, and the interrupt, both latch outputs, both strobes, `rd_valid` and `wr_ready` are low.
- R2: A command write (`reg_sel`=0) with bit 31 set starts an operation. Status bit 31 reads 1 from the next cycle until the operation ends, then reads 0.
- R3: The first bus action of an accepted command is exactly one write strobe with `nf_cle` high and the opcode (command bits 23:16) on `nf_io_out`; `nf_cle` and `nf_ale` are never high together.
- R4: For each set bit of the mask (command bits 28:24), lowest bit first, one write strobe with `nf_ale` high is issued. Mask bit 0 sends column bits 7:0, bit 1 sends column bits 15:8, bits 2, 3 and 4 send page bits 7:0, 15:8 and 23:16.
- R5: With command bit 15 set, no data strobe is issued until `nf_rdy` is sampled high after the address phase.
- R6: With command bit 13 set, exactly count (bits 11:0) read strobes are issued. Each byte on `nf_io_in` during a read strobe appears once, in order, on `rd_data` with `rd_valid` in the next cycle.
- R7: With command bit 14 set (and bit 13 clear), exactly count bytes are taken from `wr_data`, one per cycle in which `wr_ready` and `wr_valid` are both high, and driven in order with a write strobe and both latches low. No byte moves while `wr_valid` is low.
- R8: At the end of an operation (normal, timed-out or refused) `irq` pulses for exactly one cycle if command bit 30 was set, and stays low otherwise.
- R9: Opcodes 0x80, 0x10, 0x60 and 0xd0 whose page register value is below MIN_PAGE (default 0x200) or at or above MAX_PAGE (default 0x40000) are refused: no strobe is issued, status bit 31 stays 0 and status bit 29 (error) is set. Other opcodes are never refused.
- R10: If `nf_rdy` is still low when the wait has lasted the timeout limit (`reg_sel`=3) in cycles, the operation ends with the error bit set and no data is moved. A ready that arrives in the same cycle as the expiry wins.
- R11: A command write with bit 31 clear stops any operation at once: busy and error read 0, and no further strobe, latch or interrupt follows.
- R12: The error bit stays set until the next command write, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select: 0 command, 1 column, 2 page, 3 timeout |
| reg_wdata | input | 32 | Register write data |
| cmd_status | output | 32 | Command word readback with busy (31) and error (29) |
| irq | output | 1 | One-cycle completion interrupt |
| nf_io_out | output | 8 | Byte driven to the flash |
| nf_io_in | input | 8 | Byte returned by the flash during a read strobe |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_wstb | output | 1 | One-cycle write strobe |
| nf_rstb | output | 1 | One-cycle read strobe |
| nf_rdy | input | 1 | Flash ready (high) / busy (low) |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Sequencer takes the write byte this cycle |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |

## Verification
The two events that can collide are the flash ready line returning and the ready-wait timer expiring, both sampled at the same edge of the wait state. The bench's flash model holds ready low for a chosen number of cycles after a confirm opcode. Setting the timeout limit equal to that number makes both arrive together, and the operation must then complete without error and move its data. With a limit one lower, the same stimulus must end in the error state with no data moved.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
  localparam int NUM_ADDR = 5;
  localparam int CNT_W    = 12;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_COL  = 2'd1;
  localparam logic [1:0] SEL_PAGE = 2'd2;
  localparam logic [1:0] SEL_TMO  = 2'd3;

  // opcodes that modify the array and are range-checked
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_PROG_CONF   = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_CONF  = 8'hd0;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} seq_state_e;
endpackage

// File: rtl/nfc_guard.sv
`timescale 1ns/1ps
module nfc_guard #(
  parameter int ROW_W    = 24,
  parameter int MIN_PAGE = 32'h200,
  parameter int MAX_PAGE = 32'h40000
) (
  input  logic [7:0]       opcode,
  input  logic [ROW_W-1:0] page,
  output logic             refuse
);
  import nfc_pkg::*;
  localparam logic [ROW_W-1:0] LO = ROW_W'(MIN_PAGE);
  localparam logic [ROW_W-1:0] HI = ROW_W'(MAX_PAGE);

  logic modifying;
  always_comb begin
    modifying = (opcode == OP_PROG_SETUP) || (opcode == OP_PROG_CONF) ||
                (opcode == OP_ERASE_SETUP) || (opcode == OP_ERASE_CONF);
    refuse    = modifying && ((page < LO) || (page >= HI));
  end
endmodule

// File: rtl/nfc_addr_pick.sv
`timescale 1ns/1ps
module nfc_addr_pick #(
  parameter int COL_W = 16,
  parameter int ROW_W = 24
) (
  input  logic [nfc_pkg::NUM_ADDR-1:0] mask,
  input  logic [COL_W-1:0]             col,
  input  logic [ROW_W-1:0]             page,
  output logic                         hit,
  output logic [nfc_pkg::NUM_ADDR-1:0] sel_oh,
  output logic [7:0]                   sel_byte
);
  import nfc_pkg::*;
  localparam int FLAT_W = COL_W + ROW_W;
  logic [FLAT_W-1:0] flat;

  // lowest set mask bit wins: scan from the top so lower indices overwrite
  always_comb begin
    flat     = {page, col};
    sel_oh   = '0;
    sel_byte = '0;
    for (int i = NUM_ADDR - 1; i >= 0; i--) begin
      if (mask[i]) begin
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
        sel_byte  = flat[i*8 +: 8];
      end
    end
    hit = |mask;
  end
endmodule

// File: rtl/nfc_timer.sv
`timescale 1ns/1ps
module nfc_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt <= '0;
    else if (cnt != limit)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == limit);
endmodule

// File: rtl/nfc_seq.sv
`timescale 1ns/1ps
module nfc_seq #(
  parameter int COL_W     = 16,
  parameter int ROW_W     = 24,
  parameter int TMO_W     = 16,
  parameter int MIN_PAGE  = 32'h200,
  parameter int MAX_PAGE  = 32'h40000,
  parameter int TMO_RESET = 16'hffff
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] cmd_status,
  output logic        irq,
  output logic [7:0]  nf_io_out,
  input  logic [7:0]  nf_io_in,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_wstb,
  output logic        nf_rstb,
  input  logic        nf_rdy,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [7:0]  rd_data,
  output logic        rd_valid
);
  import nfc_pkg::*;

  seq_state_e            state;
  logic [31:0]           cmd_q;
  logic [COL_W-1:0]      col_q;
  logic [ROW_W-1:0]      page_q;
  logic [TMO_W-1:0]      tmo_q;
  logic                  busy, err;
  logic [NUM_ADDR-1:0]   mask_rem;
  logic                  wait_pend;
  logic [CNT_W-1:0]      cnt_rem;

  logic                  cmd_wr, start, refuse, pick_hit, tmo_exp;
  logic [NUM_ADDR-1:0]   pick_oh;
  logic [7:0]            pick_byte;
  logic                  cfg_ie, cfg_rd, cfg_wr;

  assign cmd_wr = reg_we && (reg_sel == SEL_CMD);
  assign start  = cmd_wr && reg_wdata[31];
  assign cfg_ie = cmd_q[30];
  assign cfg_wr = cmd_q[14];
  assign cfg_rd = cmd_q[13];

  nfc_guard #(.ROW_W(ROW_W), .MIN_PAGE(MIN_PAGE), .MAX_PAGE(MAX_PAGE)) u_guard (
    .opcode(reg_wdata[23:16]), .page(page_q), .refuse(refuse));

  nfc_addr_pick #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pick (
    .mask(mask_rem), .col(col_q), .page(page_q),
    .hit(pick_hit), .sel_oh(pick_oh), .sel_byte(pick_byte));

  nfc_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .limit(tmo_q), .expired(tmo_exp));

  assign wr_ready = (state == ST_RUN) && !cmd_wr && !pick_hit && !wait_pend &&
                    (cnt_rem != '0) && !cfg_rd && cfg_wr;

  always_comb begin
    cmd_status     = cmd_q;
    cmd_status[31] = busy;
    cmd_status[29] = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_q     <= '0;
      col_q     <= '0;
      page_q    <= '0;
      tmo_q     <= TMO_W'(TMO_RESET);
      busy      <= 1'b0;
      err       <= 1'b0;
      mask_rem  <= '0;
      wait_pend <= 1'b0;
      cnt_rem   <= '0;
      irq       <= 1'b0;
      nf_io_out <= '0;
      nf_cle    <= 1'b0;
      nf_ale    <= 1'b0;
      nf_wstb   <= 1'b0;
      nf_rstb   <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      irq      <= 1'b0;
      nf_cle   <= 1'b0;
      nf_ale   <= 1'b0;
      nf_wstb  <= 1'b0;
      nf_rstb  <= 1'b0;
      rd_valid <= nf_rstb;
      if (nf_rstb) rd_data <= nf_io_in;

      if (reg_we && reg_sel == SEL_COL)  col_q  <= reg_wdata[COL_W-1:0];
      if (reg_we && reg_sel == SEL_PAGE) page_q <= reg_wdata[ROW_W-1:0];
      if (reg_we && reg_sel == SEL_TMO)  tmo_q  <= reg_wdata[TMO_W-1:0];

      if (cmd_wr) begin
        cmd_q <= reg_wdata;
        err   <= 1'b0;
        if (!reg_wdata[31]) begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end else if (refuse) begin
          busy  <= 1'b0;
          err   <= 1'b1;
          irq   <= reg_wdata[30];
          state <= ST_IDLE;
        end else begin
          busy      <= 1'b1;
          state     <= ST_RUN;
          nf_cle    <= 1'b1;
          nf_wstb   <= 1'b1;
          nf_io_out <= reg_wdata[23:16];
          mask_rem  <= reg_wdata[28:24];
          wait_pend <= reg_wdata[15];
          cnt_rem   <= (reg_wdata[14] || reg_wdata[13]) ? reg_wdata[CNT_W-1:0] : '0;
        end
      end else begin
        case (state)
          ST_RUN: begin
            if (pick_hit) begin
              nf_ale    <= 1'b1;
              nf_wstb   <= 1'b1;
              nf_io_out <= pick_byte;
              mask_rem  <= mask_rem & ~pick_oh;
            end else if (wait_pend) begin
              wait_pend <= 1'b0;
              state     <= ST_WAIT;
            end else if (cnt_rem != '0) begin
              if (cfg_rd) begin
                nf_rstb <= 1'b1;
                cnt_rem <= cnt_rem - 1'b1;
              end else if (wr_valid) begin
                nf_io_out <= wr_data;
                nf_wstb   <= 1'b1;
                cnt_rem   <= cnt_rem - 1'b1;
              end
            end else if (!nf_rstb) begin
              busy  <= 1'b0;
              irq   <= cfg_ie;
              state <= ST_IDLE;
            end
          end
          ST_WAIT: begin
            if (nf_rdy) begin
              state <= ST_RUN;
            end else if (tmo_exp) begin
              err   <= 1'b1;
              busy  <= 1'b0;
              irq   <= cfg_ie;
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: latches never overlap, command latch only inside an operation
  a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));
  a_r3_cle_in_busy: assert property (@(posedge clk) disable iff (rst)
    nf_cle |-> busy);
  // R2: idle state never reports busy
  a_r2_idle_not_busy: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !busy);
  // R5: bus is silent while waiting for ready
  a_r5_quiet_in_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !(nf_wstb || nf_rstb));
  // R7: a data write byte only follows an offered stream byte
  a_r7_data_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (nf_wstb && !nf_cle && !nf_ale) |-> $past(wr_valid));
  // R8: interrupt lasts one cycle unless a new command ends at once
  a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
    (irq && !cmd_wr) |=> !irq);
  // R9: refused command leaves the bus alone and flags error
  a_r9_refused_quiet: assert property (@(posedge clk) disable iff (rst)
    (start && refuse) |=> (!nf_wstb && !nf_cle && err && !busy));
  // R10: timeout ends the operation with error
  a_r10_timeout_err: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !nf_rdy && tmo_exp && !cmd_wr) |=> (err && !busy));
endmodule

// File: tb/test_nfc_seq.sv
`timescale 1ns/1ps
module test_nfc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cmd_status;
  logic        irq, nf_cle, nf_ale, nf_wstb, nf_rstb, nf_rdy;
  logic [7:0]  nf_io_out, nf_io_in, wr_data, rd_data;
  logic        wr_valid, wr_ready, rd_valid;
  logic        wr_hold = 1'b0;
  logic        clr_req = 1'b0;
  int          busy_len = 6;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  nfc_seq i_nfc_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_status(cmd_status), .irq(irq), .nf_io_out(nf_io_out), .nf_io_in(nf_io_in),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_wstb(nf_wstb), .nf_rstb(nf_rstb),
    .nf_rdy(nf_rdy), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid));

  // flash model and bus monitor
  int busy_left;
  int cle_n, ale_n, wd_n, rd_n, rs_n, ws_n, bad_wd, bad_rd, early_rd, irq_n, irq_long;
  logic [7:0] ale_log [8];
  logic [7:0] last_op;
  logic       irq_d;

  assign nf_rdy   = (busy_left == 0);
  assign nf_io_in = 8'hA0 + rd_n[7:0];
  assign wr_valid = !wr_hold;
  assign wr_data  = 8'h50 + ws_n[7:0];

  always @(posedge clk) begin
    if (rst) busy_left <= 0;
    else if (nf_wstb && nf_cle && (nf_io_out == 8'h30 || nf_io_out == 8'h10 ||
             nf_io_out == 8'hd0 || nf_io_out == 8'hff)) busy_left <= busy_len;
    else if (busy_left != 0) busy_left <= busy_left - 1;
  end

  always @(posedge clk) begin
    irq_d <= irq;
    if (clr_req || rst) begin
      cle_n <= 0; ale_n <= 0; wd_n <= 0; rd_n <= 0; rs_n <= 0; ws_n <= 0;
      bad_wd <= 0; bad_rd <= 0; early_rd <= 0; irq_n <= 0; irq_long <= 0;
      last_op <= '0;
    end else begin
      if (nf_wstb) begin
        if (nf_cle) begin
          cle_n <= cle_n + 1; last_op <= nf_io_out;
        end else if (nf_ale) begin
          ale_log[ale_n[2:0]] <= nf_io_out; ale_n <= ale_n + 1;
        end else begin
          if (nf_io_out != 8'h50 + wd_n[7:0]) bad_wd <= bad_wd + 1;
          wd_n <= wd_n + 1;
        end
      end
      if (nf_rstb) begin
        rd_n <= rd_n + 1;
        if (!nf_rdy) early_rd <= early_rd + 1;
      end
      if (rd_valid) begin
        if (rd_data != 8'hA0 + rs_n[7:0]) bad_rd <= bad_rd + 1;
        rs_n <= rs_n + 1;
      end
      if (wr_ready && wr_valid) ws_n <= ws_n + 1;
      if (irq) irq_n <= irq_n + 1;
      if (irq && irq_d) irq_long <= irq_long + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_counts();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (cmd_status[31] && g < 3000) begin
      @(negedge clk); g++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] mkcmd(input logic ie, input logic [4:0] mask,
      input logic [7:0] op, input logic wt, input logic wr, input logic rd,
      input logic [11:0] cnt);
    return {1'b1, ie, 1'b0, mask, op, wt, wr, rd, 1'b0, cnt};
  endfunction

  // {op, mask, wait, rd, wr, count, page, expect_error}
  localparam logic [52:0] VECS [8] = '{
    {8'h00, 5'h1f, 1'b0, 1'b0, 1'b0, 12'd0,  24'h012345, 1'b0},
    {8'h30, 5'h00, 1'b1, 1'b1, 1'b0, 12'd16, 24'h012345, 1'b0},
    {8'h80, 5'h1f, 1'b0, 1'b0, 1'b1, 12'd8,  24'h000300, 1'b0},
    {8'h10, 5'h00, 1'b1, 1'b0, 1'b0, 12'd0,  24'h000300, 1'b0},
    {8'h60, 5'h1c, 1'b0, 1'b0, 1'b0, 12'd0,  24'h0001ff, 1'b1},
    {8'hd0, 5'h00, 1'b1, 1'b0, 1'b0, 12'd0,  24'h040000, 1'b1},
    {8'h90, 5'h01, 1'b0, 1'b1, 1'b0, 12'd5,  24'h000000, 1'b0},
    {8'hff, 5'h00, 1'b1, 1'b0, 1'b0, 12'd0,  24'h000000, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", cmd_status, 32'h0);
    chk("R1 outputs", {31'd0, irq | nf_cle | nf_ale | nf_wstb | nf_rstb | rd_valid | wr_ready}, 32'h0);

    wreg(2'd1, 32'h0000_0456);
    wreg(2'd3, 32'd1000);

    for (int i = 0; i < 8; i++) begin
      logic [52:0] v;
      logic [39:0] flat;
      int k;
      v = VECS[i];
      wreg(2'd2, {8'h00, v[24:1]});
      clear_counts();
      wreg(2'd0, mkcmd(1'b1, v[44:40], v[52:45], v[39], v[37], v[38], v[36:25]));
      if (!v[0]) chk($sformatf("R2 busy set v%0d", i), {31'd0, cmd_status[31]}, 32'd1);
      else       chk($sformatf("R9 busy never set v%0d", i), {31'd0, cmd_status[31]}, 32'd0);
      wait_idle();
      chk($sformatf("R2 busy cleared v%0d", i), {31'd0, cmd_status[31]}, 32'd0);
      chk($sformatf("R9 error bit v%0d", i), {31'd0, cmd_status[29]}, {31'd0, v[0]});
      chk($sformatf("R3 cle count v%0d", i), cle_n, v[0] ? 0 : 1);
      if (!v[0]) chk($sformatf("R3 opcode v%0d", i), {24'd0, last_op}, {24'd0, v[52:45]});
      chk($sformatf("R4 ale count v%0d", i), ale_n, v[0] ? 0 : $countones(v[44:40]));
      flat = {v[24:1], 16'h0456};
      k = 0;
      for (int b = 0; b < 5; b++) begin
        if (v[44 - 4 + b] && !v[0]) begin
          chk($sformatf("R4 addr byte %0d v%0d", k, i), {24'd0, ale_log[k]}, {24'd0, flat[b*8 +: 8]});
          k++;
        end
      end
      chk($sformatf("R6 read strobes v%0d", i), rd_n, (v[38] && !v[0]) ? int'(v[36:25]) : 0);
      chk($sformatf("R6 read stream v%0d", i), rs_n, (v[38] && !v[0]) ? int'(v[36:25]) : 0);
      chk($sformatf("R6 read order v%0d", i), bad_rd, 0);
      chk($sformatf("R7 write bytes v%0d", i), wd_n, (v[37] && !v[0]) ? int'(v[36:25]) : 0);
      chk($sformatf("R7 write order v%0d", i), bad_wd, 0);
      chk($sformatf("R5 no early read v%0d", i), early_rd, 0);
      chk($sformatf("R8 irq count v%0d", i), irq_n, 1);
      chk($sformatf("R8 irq width v%0d", i), irq_long, 0);
    end

    // R8: no interrupt without bit 30
    clear_counts();
    wreg(2'd0, {1'b1, 1'b0, 1'b0, 5'h00, 8'h70, 1'b0, 1'b0, 1'b1, 1'b0, 12'd2});
    wait_idle();
    chk("R8 irq disabled", irq_n, 0);
    chk("R6 status read bytes", rs_n, 2);

    // R10: ready and expiry in the same cycle, ready wins
    busy_len = 10;
    wreg(2'd3, 32'd10);
    clear_counts();
    wreg(2'd0, mkcmd(1'b1, 5'h00, 8'h30, 1'b1, 1'b0, 1'b1, 12'd3));
    wait_idle();
    chk("R10 coincident ready no error", {31'd0, cmd_status[29]}, 32'd0);
    chk("R10 coincident ready data", rs_n, 3);
    // R10: one cycle shorter limit times out
    wreg(2'd3, 32'd9);
    clear_counts();
    wreg(2'd0, mkcmd(1'b1, 5'h00, 8'h30, 1'b1, 1'b0, 1'b1, 12'd3));
    wait_idle();
    chk("R10 timeout error", {31'd0, cmd_status[29]}, 32'd1);
    chk("R10 timeout no data", rd_n, 0);
    chk("R10 timeout irq", irq_n, 1);
    // R12: error holds until the next command write
    repeat (20) @(negedge clk);
    chk("R12 error held", {31'd0, cmd_status[29]}, 32'd1);
    wreg(2'd0, mkcmd(1'b0, 5'h00, 8'h70, 1'b0, 1'b0, 1'b1, 12'd1));
    chk("R12 error cleared by write", {31'd0, cmd_status[29]}, 32'd0);
    wait_idle();

    // R11: abort during a long ready wait
    busy_len = 200;
    wreg(2'd3, 32'd1000);
    wreg(2'd0, mkcmd(1'b1, 5'h00, 8'h30, 1'b1, 1'b0, 1'b1, 12'd4));
    repeat (5) @(negedge clk);
    wreg(2'd0, 32'h0000_0000);
    chk("R11 abort busy", {31'd0, cmd_status[31]}, 32'd0);
    chk("R11 abort error", {31'd0, cmd_status[29]}, 32'd0);
    clear_counts();
    repeat (300) @(negedge clk);
    chk("R11 no strobes after abort", cle_n + ale_n + rd_n + wd_n, 0);
    chk("R11 no irq after abort", irq_n, 0);
    busy_len = 6;

    // R7: write stream stall
    wreg(2'd2, 32'h0000_0300);
    wr_hold = 1'b1;
    clear_counts();
    wreg(2'd0, mkcmd(1'b1, 5'h00, 8'h80, 1'b0, 1'b1, 1'b0, 12'd3));
    repeat (10) @(negedge clk);
    chk("R7 stalled no bytes", wd_n, 0);
    chk("R7 stalled still busy", {31'd0, cmd_status[31]}, 32'd1);
    wr_hold = 1'b0;
    wait_idle();
    chk("R7 bytes after release", wd_n, 3);
    chk("R7 order after release", bad_wd, 0);

    // R9: window edges and unguarded opcode
    wreg(2'd2, 32'h0003_ffff);
    clear_counts();
    wreg(2'd0, mkcmd(1'b1, 5'h1c, 8'h60, 1'b0, 1'b0, 1'b0, 12'd0));
    wait_idle();
    chk("R9 top page accepted", {31'd0, cmd_status[29]}, 32'd0);
    chk("R9 top page row bytes", ale_n, 3);
    wreg(2'd2, 32'h0000_0200);
    clear_counts();
    wreg(2'd0, mkcmd(1'b1, 5'h00, 8'hd0, 1'b1, 1'b0, 1'b0, 12'd0));
    wait_idle();
    chk("R9 min page accepted", cle_n, 1);
    wreg(2'd2, 32'h0000_0000);
    clear_counts();
    wreg(2'd0, mkcmd(1'b1, 5'h1f, 8'h00, 1'b0, 1'b0, 1'b0, 12'd0));
    wait_idle();
    chk("R9 read setup not guarded", {31'd0, cmd_status[29]}, 32'd0);
    chk("R9 read setup addr bytes", ale_n, 5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule